// File: doc/BRIEF.md
# Memory return routing tracker

This block sits between the address stage and the data-return stage of a vector memory pipeline. When the address stage issues a command, it pushes a routing record into an in-order queue of eight entries. The record holds the destination SIMD, the kind of request, how many line responses the command expects, and whether the command was coalesced. While the queue holds eight records the block withdraws `cmd_ready`, and the front end has to hold the command.

Line responses from cache storage are matched against the oldest record. The block collects them until the expected count has arrived. It then releases one result pulse: the lines assembled into one word, with a one-hot select that names the recorded SIMD. A write that carries no return data completes on an acknowledge pulse and produces no result beat. Line data that arrives with no record to receive it sets a sticky error flag.

Seven free-running event counters give a view of throughput. They count busy cycles, cycles spent waiting for data, cycles the front end is stalled, accepted reads, accepted writes, accepted atomics and accepted coalesced commands.

Top module: `vmem_return_router`

## Requirements
- R1: `cmd_ready` is low exactly while the queue holds DEPTH (8) records. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high.
- R2: Results leave in the order the commands were accepted. Each result carries `res_sel` as the one-hot of the recorded SIMD (bit s for SIMD s), together with the recorded `res_kind` and `res_coal`. `res_sel` is zero when `res_valid` is low.
- R3: A read (kind 0) or atomic (kind 2) record expects `cmd_lines` line beats, from 1 to MAX_LINES (4). Beat i lands in `res_data[i*DATA_W +: DATA_W]`, and slots at or above the count read zero. `res_valid` pulses for one cycle, starting in the cycle after the edge that takes the last beat, and stays low while beats are still missing.
- R4: A write record (kind 1) is retired by a `wr_ack` pulse and raises no `res_valid`. A `wr_ack` that arrives while the oldest record is not a write has no effect.
- R5: `line_valid` while the queue is empty, or while the oldest record is a write, sets `err_flag` and discards the beat. Only reset clears `err_flag`.
- R6: `cnt_busy` increments on every cycle that the queue holds at least one record.
- R7: `cnt_wait` increments on every cycle that the oldest record is a read or an atomic and `line_valid` is low.
- R8: `cnt_fstall` increments on every cycle that has `cmd_valid` high and `cmd_ready` low.
- R9: `cnt_rd`, `cnt_wr` and `cnt_atom` count accepted commands of kind 0, 1 and 2. `cnt_coal` counts accepted commands that have `cmd_coal` high.
- R10: After reset the following hold: `cmd_ready` is 1, `res_valid` is 0, `res_sel` is 0, `err_flag` is 0 and every counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Front end offers a command |
| cmd_ready | output | 1 | Queue has room for a record |
| cmd_simd | input | SIMD_W (2) | Destination SIMD |
| cmd_kind | input | 2 | 0 read, 1 write, 2 atomic |
| cmd_lines | input | LCNT_W (3) | Line beats expected, 1..MAX_LINES |
| cmd_coal | input | 1 | Command was coalesced |
| line_valid | input | 1 | One line beat from cache storage |
| line_data | input | DATA_W (16) | Line beat payload |
| wr_ack | input | 1 | Completion pulse for a write |
| res_valid | output | 1 | Assembled result pulse |
| res_sel | output | NUM_SIMD (4) | One-hot destination SIMD |
| res_kind | output | 2 | Kind of the completed record |
| res_coal | output | 1 | Coalesced flag of the completed record |
| res_data | output | MAX_LINES*DATA_W (64) | Assembled line beats |
| err_flag | output | 1 | Sticky protocol error |
| cnt_busy | output | CNT_W (16) | Busy-cycle count |
| cnt_wait | output | CNT_W (16) | Data-wait cycle count |
| cnt_fstall | output | CNT_W (16) | Front-end stall cycle count |
| cnt_rd | output | CNT_W (16) | Accepted reads |
| cnt_wr | output | CNT_W (16) | Accepted writes |
| cnt_atom | output | CNT_W (16) | Accepted atomics |
| cnt_coal | output | CNT_W (16) | Accepted coalesced commands |

## Verification
The assertions take the inputs to be well formed in three ways. `cmd_lines` stays within 1 to 4, `cmd_kind` never uses the reserved code 3, and `wr_ack` is a single-cycle pulse. They also rely on the checker's own occupancy count, which is rebuilt from the push and pop events. The stimulus keeps within these limits by construction: it only ever drives the three defined kinds and counts from 1 to 4, and it drives acknowledges and line beats for exactly one cycle each. The only deliberate breaches of protocol are the orphan line beats that exercise the error flag.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

  typedef enum logic [1:0] {
    K_READ   = 2'd0,
    K_WRITE  = 2'd1,
    K_ATOMIC = 2'd2,
    K_RSVD   = 2'd3
  } vkind_e;

  // Force a requested line count into the legal 1..maxl range.
  function automatic int clamp_lines(input int n, input int maxl);
    if (n < 1) return 1;
    if (n > maxl) return maxl;
    return n;
  endfunction

  // True when beat number idx (zero based) completes a gather of need beats.
  function automatic logic is_last_beat(input int idx, input int need);
    return (idx + 1) == need;
  endfunction

endpackage

// File: rtl/vrt_fifo.sv
module vrt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/vrt_gather.sv
module vrt_gather #(
  parameter int DATA_W    = 16,
  parameter int MAX_LINES = 4,
  parameter int LCNT_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        beat_en,
  input  logic [DATA_W-1:0]           beat_data,
  input  logic [LCNT_W-1:0]           need,
  output logic                        beat_last,
  output logic [MAX_LINES*DATA_W-1:0] assembled
);
  logic [LCNT_W-1:0] beat_idx;
  logic [DATA_W-1:0] slot_q [MAX_LINES];

  assign beat_last = beat_en && vrt_pkg::is_last_beat(int'(beat_idx), int'(need));

  always_ff @(posedge clk) begin
    if (!rst_n)        beat_idx <= '0;
    else if (beat_last) beat_idx <= '0;
    else if (beat_en)   beat_idx <= beat_idx + 1'b1;
  end

  // One slot per line: earlier beats come from storage, the current beat
  // passes straight through, later slots read zero.
  for (genvar g = 0; g < MAX_LINES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (beat_en && !beat_last && beat_idx == LCNT_W'(g))
        slot_q[g] <= beat_data;
    end
    assign assembled[g*DATA_W +: DATA_W] =
      (beat_en && beat_idx == LCNT_W'(g)) ? beat_data :
      (LCNT_W'(g) < beat_idx)             ? slot_q[g] : '0;
  end
endmodule

// File: rtl/vrt_evt_counters.sv
module vrt_evt_counters #(
  parameter int N     = 4,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            inc,
  output logic [N-1:0][CNT_W-1:0] cnt
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)      cnt[i] <= '0;
      else if (inc[i]) cnt[i] <= cnt[i] + 1'b1;
    end
  end
endmodule

// File: rtl/vmem_return_router.sv
module vmem_return_router #(
  parameter int DEPTH     = 8,
  parameter int NUM_SIMD  = 4,
  parameter int DATA_W    = 16,
  parameter int MAX_LINES = 4,
  parameter int CNT_W     = 16,
  localparam int SIMD_W   = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
  localparam int LCNT_W   = $clog2(MAX_LINES + 1),
  localparam int RES_W    = MAX_LINES * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [SIMD_W-1:0]   cmd_simd,
  input  logic [1:0]          cmd_kind,
  input  logic [LCNT_W-1:0]   cmd_lines,
  input  logic                cmd_coal,
  input  logic                line_valid,
  input  logic [DATA_W-1:0]   line_data,
  input  logic                wr_ack,
  output logic                res_valid,
  output logic [NUM_SIMD-1:0] res_sel,
  output logic [1:0]          res_kind,
  output logic                res_coal,
  output logic [RES_W-1:0]    res_data,
  output logic                err_flag,
  output logic [CNT_W-1:0]    cnt_busy,
  output logic [CNT_W-1:0]    cnt_wait,
  output logic [CNT_W-1:0]    cnt_fstall,
  output logic [CNT_W-1:0]    cnt_rd,
  output logic [CNT_W-1:0]    cnt_wr,
  output logic [CNT_W-1:0]    cnt_atom,
  output logic [CNT_W-1:0]    cnt_coal
);
  import vrt_pkg::*;

  typedef struct packed {
    logic [SIMD_W-1:0] simd;
    logic [1:0]        kind;
    logic [LCNT_W-1:0] lines;
    logic              coal;
  } rec_t;

  localparam int REC_W = $bits(rec_t);
  localparam int NCNT  = 7;

  rec_t             rec_in, head;
  logic [REC_W-1:0] head_raw;
  logic             fifo_full, fifo_empty, head_is_wr;

  // Named internal events, shared with the bound checker.
  logic evt_push, evt_pop, evt_line, evt_last, evt_wack, evt_err;
  logic [RES_W-1:0] gathered;

  assign rec_in.simd  = cmd_simd;
  assign rec_in.kind  = cmd_kind;
  assign rec_in.lines = LCNT_W'(clamp_lines(int'(cmd_lines), MAX_LINES));
  assign rec_in.coal  = cmd_coal;

  vrt_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(evt_push), .din(rec_in),
    .pop(evt_pop), .dout(head_raw),
    .full(fifo_full), .empty(fifo_empty)
  );

  assign head       = rec_t'(head_raw);
  assign head_is_wr = (head.kind == K_WRITE);
  assign cmd_ready  = !fifo_full;

  assign evt_push = cmd_valid && !fifo_full;
  assign evt_line = line_valid && !fifo_empty && !head_is_wr;
  assign evt_err  = line_valid && (fifo_empty || head_is_wr);
  assign evt_wack = wr_ack && !fifo_empty && head_is_wr;
  assign evt_pop  = evt_last || evt_wack;

  vrt_gather #(.DATA_W(DATA_W), .MAX_LINES(MAX_LINES), .LCNT_W(LCNT_W)) u_gather (
    .clk(clk), .rst_n(rst_n),
    .beat_en(evt_line), .beat_data(line_data), .need(head.lines),
    .beat_last(evt_last), .assembled(gathered)
  );

  // Result register: one pulse per completed read or atomic.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_sel   <= '0;
      res_kind  <= '0;
      res_coal  <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= evt_last;
      res_sel   <= evt_last ? (NUM_SIMD'(1) << head.simd) : '0;
      if (evt_last) begin
        res_kind <= head.kind;
        res_coal <= head.coal;
        res_data <= gathered;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       err_flag <= 1'b0;
    else if (evt_err) err_flag <= 1'b1;
  end

  logic [NCNT-1:0]            cnt_inc;
  logic [NCNT-1:0][CNT_W-1:0] cnt_all;

  assign cnt_inc[0] = !fifo_empty;
  assign cnt_inc[1] = !fifo_empty && !head_is_wr && !line_valid;
  assign cnt_inc[2] = cmd_valid && fifo_full;
  assign cnt_inc[3] = evt_push && (cmd_kind == K_READ);
  assign cnt_inc[4] = evt_push && (cmd_kind == K_WRITE);
  assign cnt_inc[5] = evt_push && (cmd_kind == K_ATOMIC);
  assign cnt_inc[6] = evt_push && cmd_coal;

  vrt_evt_counters #(.N(NCNT), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .cnt(cnt_all)
  );

  assign cnt_busy   = cnt_all[0];
  assign cnt_wait   = cnt_all[1];
  assign cnt_fstall = cnt_all[2];
  assign cnt_rd     = cnt_all[3];
  assign cnt_wr     = cnt_all[4];
  assign cnt_atom   = cnt_all[5];
  assign cnt_coal   = cnt_all[6];
endmodule

// File: rtl/vmem_return_router_chk.sv
module vmem_return_router_chk #(
  parameter int DEPTH    = 8,
  parameter int NUM_SIMD = 4,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic                evt_push,
  input logic                evt_pop,
  input logic                evt_last,
  input logic                evt_wack,
  input logic                evt_err,
  input logic                fifo_empty,
  input logic                res_valid,
  input logic [NUM_SIMD-1:0] res_sel,
  input logic                err_flag,
  input logic [CNT_W-1:0]    cnt_busy,
  input logic [CNT_W-1:0]    cnt_fstall
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  // Occupancy rebuilt from the push and pop events alone.
  logic [OCC_W-1:0] occ;
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + OCC_W'(evt_push) - OCC_W'(evt_pop);
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_push |-> (occ < OCC_W'(DEPTH)));
  p_ready_tracks_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready == (occ < OCC_W'(DEPTH)));
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pop |-> (occ != '0));
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot(res_sel));
  p_sel_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_sel == '0));
  p_result_follows_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last |=> res_valid);
  p_result_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(evt_last));
  p_write_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wack |=> !res_valid);
  p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> err_flag);
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  p_busy_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_empty |=> (cnt_busy == CNT_W'($past(cnt_busy) + 1'b1)));
  p_fstall_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cnt_fstall == CNT_W'($past(cnt_fstall) + 1'b1)));
endmodule

bind vmem_return_router vmem_return_router_chk #(
  .DEPTH(DEPTH), .NUM_SIMD(NUM_SIMD), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .evt_push(evt_push), .evt_pop(evt_pop), .evt_last(evt_last),
  .evt_wack(evt_wack), .evt_err(evt_err), .fifo_empty(fifo_empty),
  .res_valid(res_valid), .res_sel(res_sel), .err_flag(err_flag),
  .cnt_busy(cnt_busy), .cnt_fstall(cnt_fstall)
);

// File: tb/vmem_return_router_tb.sv
module vmem_return_router_tb;
  localparam int DEPTH = 8, NSIMD = 4, DW = 16, ML = 4, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_coal = 0, line_valid = 0, wr_ack = 0;
  logic [1:0] cmd_simd = 0, cmd_kind = 0;
  logic [2:0] cmd_lines = 1;
  logic [DW-1:0] line_data = 0;
  logic cmd_ready, res_valid, res_coal, err_flag;
  logic [NSIMD-1:0] res_sel;
  logic [1:0] res_kind;
  logic [ML*DW-1:0] res_data;
  logic [CW-1:0] cnt_busy, cnt_wait, cnt_fstall, cnt_rd, cnt_wr, cnt_atom, cnt_coal;

  vmem_return_router u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_simd(cmd_simd), .cmd_kind(cmd_kind), .cmd_lines(cmd_lines), .cmd_coal(cmd_coal),
    .line_valid(line_valid), .line_data(line_data), .wr_ack(wr_ack),
    .res_valid(res_valid), .res_sel(res_sel), .res_kind(res_kind), .res_coal(res_coal),
    .res_data(res_data), .err_flag(err_flag), .cnt_busy(cnt_busy), .cnt_wait(cnt_wait),
    .cnt_fstall(cnt_fstall), .cnt_rd(cnt_rd), .cnt_wr(cnt_wr), .cnt_atom(cnt_atom),
    .cnt_coal(cnt_coal)
  );

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model of occupancy and counters, driven from bench inputs only.
  int m_occ, m_rp, m_wp, m_beat;
  int m_kind [DEPTH];
  int m_lines [DEPTH];
  int m_busy, m_wait, m_fst, m_rd, m_wr, m_at, m_co;
  bit m_hw, m_pop;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_occ = 0; m_rp = 0; m_wp = 0; m_beat = 0;
      m_busy = 0; m_wait = 0; m_fst = 0; m_rd = 0; m_wr = 0; m_at = 0; m_co = 0;
    end else begin
      m_hw  = (m_occ > 0) && (m_kind[m_rp] == 1);
      m_pop = 0;
      if (m_occ > 0) m_busy++;
      if (m_occ > 0 && !m_hw && !line_valid) m_wait++;
      if (cmd_valid && m_occ == DEPTH) m_fst++;
      if (line_valid && m_occ > 0 && !m_hw) begin
        if (m_beat + 1 == m_lines[m_rp]) begin m_pop = 1; m_beat = 0; end
        else m_beat++;
      end
      if (wr_ack && m_hw) m_pop = 1;
      if (cmd_valid && m_occ < DEPTH) begin
        m_kind[m_wp]  = int'(cmd_kind);
        m_lines[m_wp] = int'(cmd_lines);
        m_wp = (m_wp + 1) % DEPTH;
        m_occ++;
        if (cmd_kind == 0) m_rd++;
        if (cmd_kind == 1) m_wr++;
        if (cmd_kind == 2) m_at++;
        if (cmd_coal) m_co++;
      end
      if (m_pop) begin m_rp = (m_rp + 1) % DEPTH; m_occ--; end
    end
  end

  // Expected-result queue.
  int e_simd [256], e_kind [256], e_lines [256], e_coal [256], e_id [256];
  int e_head = 0, e_tail = 0, next_id = 0;

  function automatic logic [DW-1:0] dval(input int id, input int b);
    return DW'(16'hA000 + id * 8 + b);
  endfunction

  task automatic issue(input int s, input int k, input int l, input int c);
    cmd_valid = 1; cmd_simd = 2'(s); cmd_kind = 2'(k); cmd_lines = 3'(l); cmd_coal = c[0];
    e_simd[e_tail] = s; e_kind[e_tail] = k; e_lines[e_tail] = l; e_coal[e_tail] = c;
    e_id[e_tail] = next_id; e_tail++; next_id++;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic deliver_head();
    logic [ML*DW-1:0] exp_d = '0;
    int id = e_id[e_head], l = e_lines[e_head];
    for (int b = 0; b < l; b++) begin
      line_valid = 1; line_data = dval(id, b);
      exp_d[b*DW +: DW] = dval(id, b);
      @(negedge clk);
      line_valid = 0;
      if (b < l - 1) check("R3 no early release", 64'(res_valid), 64'd0);
    end
    check("R3 result pulse", 64'(res_valid), 64'd1);
    check("R2 res_sel", 64'(res_sel), 64'(4'b1 << e_simd[e_head]));
    check("R2 res_kind", 64'(res_kind), 64'(e_kind[e_head]));
    check("R2 res_coal", 64'(res_coal), 64'(e_coal[e_head]));
    check("R3 res_data", res_data, exp_d);
    e_head++;
  endtask

  task automatic ack_head();
    wr_ack = 1;
    @(negedge clk);
    wr_ack = 0;
    check("R4 write no result", 64'(res_valid), 64'd0);
    e_head++;
  endtask

  task automatic drain();
    while (e_head < e_tail) begin
      if (e_kind[e_head] == 1) ack_head();
      else deliver_head();
    end
    @(negedge clk);
  endtask

  task automatic check_counters();
    check("R6 cnt_busy", 64'(cnt_busy), 64'(m_busy));
    check("R7 cnt_wait", 64'(cnt_wait), 64'(m_wait));
    check("R8 cnt_fstall", 64'(cnt_fstall), 64'(m_fst));
    check("R9 cnt_rd", 64'(cnt_rd), 64'(m_rd));
    check("R9 cnt_wr", 64'(cnt_wr), 64'(m_wr));
    check("R9 cnt_atom", 64'(cnt_atom), 64'(m_at));
    check("R9 cnt_coal", 64'(cnt_coal), 64'(m_co));
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R10 ready", 64'(cmd_ready), 64'd1);
    check("R10 res_valid", 64'(res_valid), 64'd0);
    check("R10 res_sel", 64'(res_sel), 64'd0);
    check("R10 err_flag", 64'(err_flag), 64'd0);
    check("R10 counters", 64'(cnt_busy | cnt_wait | cnt_fstall | cnt_rd | cnt_wr | cnt_atom | cnt_coal), 64'd0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2/R3/R9: sweep every SIMD, line count and data-bearing kind.
    for (int s = 0; s < NSIMD; s++)
      for (int l = 1; l <= ML; l++)
        for (int k = 0; k <= 2; k += 2) begin
          issue(s, k, l, (s + l) % 2);
          deliver_head();
        end

    // R4: write retired by acknowledge; stray acknowledge on a read ignored.
    issue(1, 1, 1, 0);
    ack_head();
    issue(2, 0, 2, 1);
    wr_ack = 1; @(negedge clk); wr_ack = 0;
    check("R4 stray ack ignored", 64'(res_valid), 64'd0);
    deliver_head();

    // R1/R8/R2: fill the queue, hold a ninth command, drain in order.
    for (int i = 0; i < DEPTH; i++)
      issue(i % NSIMD, (i % 3 == 1) ? 1 : ((i % 2 == 0) ? 0 : 2), (i % ML) + 1, i % 2);
    check("R1 full not ready", 64'(cmd_ready), 64'd0);
    cmd_valid = 1; cmd_kind = 2'd0; cmd_lines = 3'd1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 held while full", 64'(cmd_ready), 64'd0);
    end
    cmd_valid = 0;
    if (e_kind[e_head] == 1) ack_head(); else deliver_head();
    check("R1 ready after pop", 64'(cmd_ready), 64'd1);
    drain();
    check_counters();

    // R5: line beat while the head is a write is discarded and flags error.
    issue(3, 1, 1, 0);
    line_valid = 1; line_data = 16'hDEAD; @(negedge clk); line_valid = 0;
    check("R5 err on write head", 64'(err_flag), 64'd1);
    check("R5 no result", 64'(res_valid), 64'd0);
    ack_head();
    issue(0, 0, 1, 0);
    deliver_head();
    check("R5 err sticky", 64'(err_flag), 64'd1);
    check_counters();

    // R10 then R5: reset clears the flag; beat with empty queue sets it.
    do_reset();
    line_valid = 1; line_data = 16'hBEEF; @(negedge clk); line_valid = 0;
    check("R5 err on empty", 64'(err_flag), 64'd1);
    repeat (3) @(negedge clk);
    check("R5 err holds", 64'(err_flag), 64'd1);
    issue(2, 2, 2, 1);
    deliver_head();
    @(negedge clk);
    check_counters();

    finish_run();
  end
endmodule